// File: doc/BRIEF.md
# Planar Memory Read and Color Compare

This block is the host read path of a four-plane graphics controller. Every memory word read from display memory holds one byte per plane. On each host read strobe the block takes in the whole word and stores it in a 32-bit latch, which the write path uses later. In the same cycle it registers one byte for the host.

The returned byte depends on a one-bit read mode. In plane mode the byte comes from the single plane picked by a two-bit plane selector. In compare mode each of the eight pixel positions makes a 4-bit colour from the four planes, one bit per plane. That colour is checked against a reference colour. Only the planes enabled by a participation mask take part in the check. Each bit of the result is 1 where the colour matches.

Top module: `plane_read_path`

## Requirements
- R1: After reset the latch output and the host byte are both 0.
- R2: On every read strobe the latch loads the full 32-bit memory word, in either read mode. Plane p occupies bits 8p+7..8p. The latch appears at the output one clock after the strobe.
- R3: With no read strobe, the latch and the host byte keep their values, even when the memory word or any setting changes.
- R4: With read mode 0, the host byte one clock after a strobe is the byte of the plane given by the 2-bit plane selector.
- R5: With read mode 1, result bit i is 1 when, for every plane p whose mask bit p is 1, bit i of plane p equals bit p of the reference colour.
- R6: With read mode 1, a plane whose mask bit is 0 has no effect on the result.
- R7: With read mode 1 and an all-zero mask, the host byte is 0xFF.
- R8: The host byte changes only on a clock edge at which the read strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Host read strobe |
| mem_word | input | 32 | Word read from display memory, one byte per plane |
| rd_mode | input | 1 | 0: plane mode, 1: compare mode |
| plane_sel | input | 2 | Plane returned in mode 0 |
| ref_color | input | 4 | Reference colour for mode 1 |
| plane_mask | input | 4 | Planes taking part in mode 1 |
| host_byte | output | 8 | Registered byte returned to the host |
| latch_q | output | 32 | Latch contents |

## Verification
The assertions check on every cycle that the latch copies the previous cycle's word on a strobe and stays still without one (R2, R3, R8). They also check that the mode-0 byte matches the selected plane of the captured word (R4), and that an all-zero mask gives 0xFF (R7). The bench's sweeps are needed to show that the compare logic itself is right. They cover every reference colour against every mask over varied words, check that masked-off planes cannot change the result (R5, R6), and cover the reset values.

// File: rtl/plane_read_pkg.sv
package plane_read_pkg;
  localparam int NPLANES = 4;
  localparam int PW = 8;
  localparam int WW = NPLANES * PW;

  typedef enum logic {RM_PLANE = 1'b0, RM_COMPARE = 1'b1} rd_mode_e;

  function automatic logic [PW-1:0] plane_byte(input logic [WW-1:0] w, input logic [1:0] sel);
    return w[sel*PW +: PW];
  endfunction
endpackage

// File: rtl/plane_select.sv
module plane_select
  import plane_read_pkg::*;
(
  input  logic [WW-1:0] word_i,
  input  logic [1:0]    sel_i,
  output logic [PW-1:0] byte_o
);
  assign byte_o = plane_byte(word_i, sel_i);
endmodule

// File: rtl/color_match.sv
module color_match
  import plane_read_pkg::*;
(
  input  logic [WW-1:0]      word_i,
  input  logic [NPLANES-1:0] ref_i,
  input  logic [NPLANES-1:0] mask_i,
  output logic [PW-1:0]      hit_o
);
  for (genvar i = 0; i < PW; i++) begin : g_pix
    logic [NPLANES-1:0] diff;
    for (genvar p = 0; p < NPLANES; p++) begin : g_pl
      assign diff[p] = (word_i[p*PW+i] ^ ref_i[p]) & mask_i[p];
    end
    assign hit_o[i] = ~|diff;
  end
endmodule

// File: rtl/plane_read_path.sv
module plane_read_path
  import plane_read_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_stb,
  input  logic [31:0] mem_word,
  input  logic        rd_mode,
  input  logic [1:0]  plane_sel,
  input  logic [3:0]  ref_color,
  input  logic [3:0]  plane_mask,
  output logic [7:0]  host_byte,
  output logic [31:0] latch_q
);
  logic [PW-1:0] sel_byte, cmp_byte, next_byte;

  plane_select u_sel (.word_i(mem_word), .sel_i(plane_sel), .byte_o(sel_byte));
  color_match  u_cmp (.word_i(mem_word), .ref_i(ref_color), .mask_i(plane_mask), .hit_o(cmp_byte));

  assign next_byte = (rd_mode_e'(rd_mode) == RM_COMPARE) ? cmp_byte : sel_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      host_byte <= '0;
    end else if (rd_stb) begin
      latch_q   <= mem_word;
      host_byte <= next_byte;
    end
  end

  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> latch_q == $past(mem_word));
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(latch_q));
  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(host_byte));
  p_plane_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_mode) |=> host_byte == plane_byte(latch_q, $past(plane_sel)));
  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode && plane_mask == 4'h0) |=> host_byte == 8'hFF);
endmodule

// File: tb/plane_read_path_tb_top.sv
module plane_read_path_tb_top;
  logic clk = 0, rst_n = 0, rd_stb = 0, rd_mode = 0;
  logic [31:0] mem_word = 0;
  logic [1:0] plane_sel = 0;
  logic [3:0] ref_color = 0, plane_mask = 0;
  logic [7:0] host_byte;
  logic [31:0] latch_q;
  int n_chk = 0, n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  plane_read_path dut_i (.*);

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [7:0] ref_cmp(input logic [31:0] w, input logic [3:0] rc, input logic [3:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int ok = 1;
      for (int p = 0; p < 4; p++)
        if (m[p] && (((w >> (8*p + i)) & 1) != rc[p])) ok = 0;
      r[i] = ok[0];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] w, input logic m, input logic [1:0] s,
                         input logic [3:0] rc, input logic [3:0] mk);
    @(negedge clk);
    mem_word = w; rd_mode = m; plane_sel = s; ref_color = rc; plane_mask = mk; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0] hb;
    logic [31:0] lq;
    repeat (3) @(negedge clk);
    chk("R1 latch", latch_q, 0);
    chk("R1 byte", {24'h0, host_byte}, 0);
    rst_n = 1;
    // R4 plane mode, every plane
    for (int k = 0; k < 32; k++) begin
      seed = nxt(seed); w = seed;
      do_read(w, 0, k[1:0], 4'h0, 4'h0);
      chk("R4", {24'h0, host_byte}, (w >> (8 * k[1:0])) & 32'hFF);
      chk("R2 mode0", latch_q, w);
    end
    // R5/R7 sweep of reference and mask
    for (int rc = 0; rc < 16; rc++)
      for (int mk = 0; mk < 16; mk++)
        for (int t = 0; t < 4; t++) begin
          seed = nxt(seed); w = seed;
          if (t == 0) w = {{8{rc[3]}}, {8{rc[2]}}, {8{rc[1]}}, {8{rc[0]}}} ^ 32'h0100_8001;
          do_read(w, 1, 2'd0, rc[3:0], mk[3:0]);
          if (mk == 0) chk("R7", {24'h0, host_byte}, 32'hFF);
          else chk("R5", {24'h0, host_byte}, {24'h0, ref_cmp(w, rc[3:0], mk[3:0])});
          chk("R2 mode1", latch_q, w);
          // R6: flip a masked-off plane, result must not change
          if (mk != 15) begin
            int p = 0;
            while (mk[p]) p++;
            hb = host_byte;
            do_read(w ^ (32'hFF << (8 * p)), 1, 2'd0, rc[3:0], mk[3:0]);
            chk("R6", {24'h0, host_byte}, {24'h0, hb});
          end
        end
    // R3/R8 hold without strobe
    hb = host_byte; lq = latch_q;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      seed = nxt(seed);
      mem_word = seed; rd_mode = seed[0]; plane_sel = seed[2:1];
      ref_color = seed[6:3]; plane_mask = seed[10:7];
      @(negedge clk);
      chk("R3 latch", latch_q, lq);
      chk("R8 byte", {24'h0, host_byte}, {24'h0, hb});
    end
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule